// File: doc/BRIEF.md
# Wavefront Issue Readiness Gate

This block sits beside the instruction buffer of one wavefront and answers, every cycle, a single question from the issue scheduler: may the oldest buffered instruction go to the execution class the scheduler is offering right now? The scheduler presents the offered class and the decoded category and access kind of the head instruction, together with the wavefront's run state, an operand-hazard verdict and the free space in the global and local request queues. The block returns a combinational ready flag. When the scheduler raises `issue_en` while ready is high, the instruction counts as issued in that cycle.

The gate owns the per-wavefront memory-ordering state and the occupancy timers it depends on. Four in-pipe counters and four outstanding counters track global reads, global writes, local reads and local writes. A read cannot pass a pending write of its own space, and a write cannot pass a pending read. Issue arms countdown timers: one for the ALU issue slot, one each for the global and local issue slots, one each for the global and local register-to-memory buses, and one for the ALU pipe. A barrier puts the wavefront into a stall that lasts until the whole work group has arrived. Completion traffic comes back as `launch` pulses, which move a request from in-pipe to outstanding, and `retire` pulses, which remove it.

Top module: `wf_issue_gate`

## Requirements
- R1: `rdy` is 0 whenever `run_state` is not 01 (00 stopped, 10 returning, 11 treated as stopped) or `buf_empty` is 1.
- R2: Codes. `req_class` uses 0 ALU, 1 global, 2 shared, 3 private, 4 flat. `op_cls` uses 0 general ALU, 1 nop, 2 barrier, 3 return, 4 global memory, 5 local memory, 6 private memory, 7 flat. `op_kind` uses 0 read, 1 write, 2 atomic. Categories 0 to 3 need class 0, and categories 4, 5, 6 and 7 need classes 1, 2, 3 and 4. Any other pairing gives `rdy` 0.
- R3: A global or private read or atomic is not ready while any global write is in the pipe or outstanding. A global or private write or atomic is not ready while any global read is in the pipe or outstanding.
- R4: Local-memory operations follow the rule of R3, using the local read and write counters.
- R5: Barrier and return need a free ALU slot and all eight counters at zero. A nop needs only a free ALU slot. A general ALU op needs a free ALU slot and `opnd_ok`.
- R6: Global and private ops need a free global slot, a free global bus, `gfifo_room` and `opnd_ok`. Local ops need the local equivalents. Flat needs both slots, both buses, both queue rooms and `opnd_ok`.
- R7: Counter lanes sit at `pipe_cnt`/`outs_cnt` bits [6i+5:6i], with lane 0 global read, 1 global write, 2 local read and 3 local write. Issuing a read adds 1 to the read lane of its space, a write adds 1 to the write lane, and an atomic adds 1 to both. Flat and private use the global lanes. `launch[i]` moves one unit of lane i from in-pipe to outstanding, and `retire[i]` removes one unit from outstanding. All changes in a cycle are applied together as a net change.
- R8: Issuing a read holds its bus (global for global, private and flat; local for local) busy for RD_BUS=4 cycles. A write or atomic holds it busy for WR_BUS=8 cycles.
- R9: Each issue holds its slot busy for ISSUE_PERIOD=4 cycles. Categories 0 to 3 use the ALU slot, and the memory categories use the slot of their bus. General ALU and return ops also raise `alu_busy` for ALU_BYPASS=3 cycles.
- R10: Issuing a barrier sets `stalled` and increments an internal barrier count. While `stalled` is 1 and `all_arrived` is 0, `rdy` is 0. When both are 1 at a clock edge, `stalled` clears and `bar_rec` takes the count, and readiness is evaluated normally in that cycle.
- R11: An `op_cls` of 8 or more, or a memory category with `op_kind` 3, drives `err` to 1 and `rdy` to 0.
- R12: Reset (synchronous, active high) clears all counters, timers, `stalled` and `bar_rec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_state | input | 2 | Wavefront run state |
| buf_empty | input | 1 | Instruction buffer empty |
| req_class | input | 3 | Execution class offered by the scheduler |
| op_cls | input | 4 | Category of the head instruction |
| op_kind | input | 2 | Memory access kind of the head instruction |
| opnd_ok | input | 1 | Operand hazards clear |
| gfifo_room | input | 1 | Global request queue can accept |
| lfifo_room | input | 1 | Local request queue can accept |
| all_arrived | input | 1 | Whole work group is at the barrier |
| issue_en | input | 1 | Scheduler takes the instruction if ready |
| launch | input | 4 | Per-lane move from in-pipe to outstanding |
| retire | input | 4 | Per-lane completion |
| rdy | output | 1 | Head instruction may issue this cycle |
| err | output | 1 | Head instruction has an unknown encoding |
| stalled | output | 1 | Wavefront is waiting at a barrier |
| alu_busy | output | 1 | ALU pipe occupied |
| bar_rec | output | 6 | Barrier count recorded at the last release |
| pipe_cnt | output | 24 | In-pipe counters, four 6-bit lanes |
| outs_cnt | output | 24 | Outstanding counters, four 6-bit lanes |

## Verification
`rdy` and `err` depend combinationally on the inputs and the registered state, so they are due in the same cycle the stimulus is applied. The bench drives on the falling edge and samples one nanosecond later. Counters, `stalled`, `bar_rec` and `alu_busy` change at the next rising edge, so the bench compares them one nanosecond after that edge against its model, which it has updated with the issue decision it predicted. A timer armed with N at an issue edge keeps its resource busy for exactly the next N sampled cycles. The bench predicts release on the (N+1)th cycle, which directly tests the 4-cycle and 8-cycle bus windows.

// File: rtl/wig_pkg.sv
`timescale 1ns/1ps
package wig_pkg;
  localparam logic [1:0] RS_RUN = 2'd1;

  localparam logic [2:0] RC_ALU = 3'd0;
  localparam logic [2:0] RC_GLB = 3'd1;
  localparam logic [2:0] RC_SHR = 3'd2;
  localparam logic [2:0] RC_PRV = 3'd3;
  localparam logic [2:0] RC_FLT = 3'd4;

  localparam logic [2:0] OC_ALU = 3'd0;
  localparam logic [2:0] OC_NOP = 3'd1;
  localparam logic [2:0] OC_BAR = 3'd2;
  localparam logic [2:0] OC_RET = 3'd3;
  localparam logic [2:0] OC_GMEM = 3'd4;
  localparam logic [2:0] OC_LMEM = 3'd5;
  localparam logic [2:0] OC_PMEM = 3'd6;
  localparam logic [2:0] OC_FLAT = 3'd7;

  localparam logic [1:0] OK_RD = 2'd0;
  localparam logic [1:0] OK_WR = 2'd1;
  localparam logic [1:0] OK_AT = 2'd2;

  localparam int LN_GR = 0;
  localparam int LN_GW = 1;
  localparam int LN_LR = 2;
  localparam int LN_LW = 3;
  localparam int LANES = 4;
endpackage

// File: rtl/wig_timer.sv
`timescale 1ns/1ps
module wig_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          busy
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8/R9: a running timer without a reload counts down by exactly one
  a_r9_countdown: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wig_pending.sv
`timescale 1ns/1ps
module wig_pending #(
  parameter int CW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   inc,
  input  logic [LANES-1:0]   launch,
  input  logic [LANES-1:0]   retire,
  output logic [LANES*CW-1:0] pipe_cnt,
  output logic [LANES*CW-1:0] outs_cnt,
  output logic [LANES-1:0]   lane_busy
);
  localparam logic [CW-1:0] CMAX = '1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CW-1:0] p_q, o_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= '0;
        o_q <= '0;
      end else begin
        p_q <= p_q + CW'(inc[i]) - CW'(launch[i]);
        o_q <= o_q + CW'(launch[i]) - CW'(retire[i]);
      end
    end

    assign pipe_cnt[i*CW +: CW] = p_q;
    assign outs_cnt[i*CW +: CW] = o_q;
    assign lane_busy[i] = (p_q != '0) || (o_q != '0);

    // R7: no lane drains below zero or wraps past its top
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
      (launch[i] && !inc[i]) |-> (p_q != '0));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (inc[i] && !launch[i]) |-> (p_q != CMAX));
    a_r7_retire_ok: assert property (@(posedge clk) disable iff (rst)
      (retire[i] && !launch[i]) |-> (o_q != '0));
  end
endmodule

// File: rtl/wig_decide.sv
`timescale 1ns/1ps
module wig_decide
  import wig_pkg::*;
(
  input  logic [1:0] run_state,
  input  logic       buf_empty,
  input  logic [2:0] req_class,
  input  logic [3:0] op_cls,
  input  logic [1:0] op_kind,
  input  logic       opnd_ok,
  input  logic       gfifo_room,
  input  logic       lfifo_room,
  input  logic       stalled,
  input  logic       all_arrived,
  input  logic       alu_slot_busy,
  input  logic       g_slot_busy,
  input  logic       l_slot_busy,
  input  logic       g_bus_busy,
  input  logic       l_bus_busy,
  input  logic [3:0] lane_busy,
  output logic       rdy,
  output logic       err
);
  logic is_mem, rd_like, wr_like, live, g_order, l_order, g_path, l_path, ok;

  always_comb begin
    is_mem  = (op_cls[3] == 1'b0) && (op_cls[2] == 1'b1);
    err     = op_cls[3] || (is_mem && (op_kind == 2'd3));
    rd_like = (op_kind == OK_RD) || (op_kind == OK_AT);
    wr_like = (op_kind == OK_WR) || (op_kind == OK_AT);
    live    = (run_state == RS_RUN) && !buf_empty && !(stalled && !all_arrived) && !err;
    g_order = !(rd_like && lane_busy[LN_GW]) && !(wr_like && lane_busy[LN_GR]);
    l_order = !(rd_like && lane_busy[LN_LW]) && !(wr_like && lane_busy[LN_LR]);
    g_path  = !g_slot_busy && !g_bus_busy && gfifo_room;
    l_path  = !l_slot_busy && !l_bus_busy && lfifo_room;
    case (op_cls[2:0])
      OC_ALU:  ok = (req_class == RC_ALU) && !alu_slot_busy && opnd_ok;
      OC_NOP:  ok = (req_class == RC_ALU) && !alu_slot_busy;
      OC_BAR,
      OC_RET:  ok = (req_class == RC_ALU) && !alu_slot_busy && (lane_busy == '0);
      OC_GMEM: ok = (req_class == RC_GLB) && g_order && g_path && opnd_ok;
      OC_PMEM: ok = (req_class == RC_PRV) && g_order && g_path && opnd_ok;
      OC_LMEM: ok = (req_class == RC_SHR) && l_order && l_path && opnd_ok;
      default: ok = (req_class == RC_FLT) && g_path && l_path && opnd_ok;
    endcase
    rdy = live && ok;
  end

  // R11: an unknown encoding is never reported ready
  always_comb begin
    a_r11_err_blocks: assert (!(err && rdy));
  end
endmodule

// File: rtl/wf_issue_gate.sv
`timescale 1ns/1ps
module wf_issue_gate
  import wig_pkg::*;
#(
  parameter int CW           = 6,
  parameter int TW           = 4,
  parameter int ISSUE_PERIOD = 4,
  parameter int ALU_BYPASS   = 3,
  parameter int RD_BUS       = 4,
  parameter int WR_BUS       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        run_state,
  input  logic              buf_empty,
  input  logic [2:0]        req_class,
  input  logic [3:0]        op_cls,
  input  logic [1:0]        op_kind,
  input  logic              opnd_ok,
  input  logic              gfifo_room,
  input  logic              lfifo_room,
  input  logic              all_arrived,
  input  logic              issue_en,
  input  logic [3:0]        launch,
  input  logic [3:0]        retire,
  output logic              rdy,
  output logic              err,
  output logic              stalled,
  output logic              alu_busy,
  output logic [CW-1:0]     bar_rec,
  output logic [4*CW-1:0]   pipe_cnt,
  output logic [4*CW-1:0]   outs_cnt
);
  localparam logic [TW-1:0] T_ISSUE = TW'(ISSUE_PERIOD);
  localparam logic [TW-1:0] T_BYP   = TW'(ALU_BYPASS);
  localparam logic [TW-1:0] T_RD    = TW'(RD_BUS);
  localparam logic [TW-1:0] T_WR    = TW'(WR_BUS);
  localparam int NT = 6;  // alu slot, g slot, l slot, g bus, l bus, alu pipe

  logic            iss, alu_grp, g_grp, l_grp, pipe_grp;
  logic [3:0]      lane_busy, inc;
  logic [NT-1:0]   t_load, t_busy;
  logic [TW-1:0]   t_val [NT];
  logic [TW-1:0]   bus_t;
  logic [CW-1:0]   bar_cnt;

  wig_decide u_dec (
    .run_state(run_state), .buf_empty(buf_empty), .req_class(req_class),
    .op_cls(op_cls), .op_kind(op_kind), .opnd_ok(opnd_ok),
    .gfifo_room(gfifo_room), .lfifo_room(lfifo_room),
    .stalled(stalled), .all_arrived(all_arrived),
    .alu_slot_busy(t_busy[0]), .g_slot_busy(t_busy[1]), .l_slot_busy(t_busy[2]),
    .g_bus_busy(t_busy[3]), .l_bus_busy(t_busy[4]),
    .lane_busy(lane_busy), .rdy(rdy), .err(err)
  );

  always_comb begin
    iss      = issue_en && rdy;
    alu_grp  = (op_cls[3:2] == 2'b00);
    l_grp    = (op_cls == {1'b0, OC_LMEM});
    g_grp    = (op_cls[3:2] == 2'b01) && !l_grp;
    pipe_grp = (op_cls == {1'b0, OC_ALU}) || (op_cls == {1'b0, OC_RET});
    bus_t    = (op_kind == OK_RD) ? T_RD : T_WR;
    inc      = '0;
    if (iss && (g_grp || l_grp)) begin
      inc[l_grp ? LN_LR : LN_GR] = (op_kind != OK_WR);
      inc[l_grp ? LN_LW : LN_GW] = (op_kind != OK_RD);
    end
    t_load = {iss && pipe_grp, iss && l_grp, iss && g_grp,
              iss && l_grp, iss && g_grp, iss && alu_grp};
    t_val[0] = T_ISSUE; t_val[1] = T_ISSUE; t_val[2] = T_ISSUE;
    t_val[3] = bus_t;   t_val[4] = bus_t;   t_val[5] = T_BYP;
  end

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    wig_timer #(.TW(TW)) u_t (
      .clk(clk), .rst(rst), .load(t_load[k]), .val(t_val[k]), .busy(t_busy[k])
    );
  end
  assign alu_busy = t_busy[5];

  wig_pending #(.CW(CW), .LANES(LANES)) u_pend (
    .clk(clk), .rst(rst), .inc(inc), .launch(launch), .retire(retire),
    .pipe_cnt(pipe_cnt), .outs_cnt(outs_cnt), .lane_busy(lane_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled <= 1'b0;
      bar_cnt <= '0;
      bar_rec <= '0;
    end else begin
      if (stalled && all_arrived) begin
        stalled <= 1'b0;
        bar_rec <= bar_cnt;
      end
      if (iss && (op_cls == {1'b0, OC_BAR})) begin
        stalled <= 1'b1;
        bar_cnt <= bar_cnt + 1'b1;
      end
    end
  end

  // R1: an idle or empty wavefront never reports ready
  a_r1_idle_blocks: assert property (@(posedge clk) disable iff (rst)
    ((run_state != RS_RUN) || buf_empty) |-> !rdy);
  // R10: a stalled wavefront waits for the group
  a_r10_barrier_hold: assert property (@(posedge clk) disable iff (rst)
    (stalled && !all_arrived) |-> !rdy);
  // R10: a barrier issue always leaves the wavefront stalled
  a_r10_barrier_sets: assert property (@(posedge clk) disable iff (rst)
    (iss && (op_cls == {1'b0, OC_BAR})) |=> stalled);
  // R3: a global read never issues past a pending global write
  a_r3_read_order: assert property (@(posedge clk) disable iff (rst)
    ((op_cls == {1'b0, OC_GMEM}) && (op_kind == OK_RD) && lane_busy[LN_GW]) |-> !rdy);
  // R5: barrier and return wait for all memory traffic
  a_r5_drain_first: assert property (@(posedge clk) disable iff (rst)
    (rdy && ((op_cls == {1'b0, OC_BAR}) || (op_cls == {1'b0, OC_RET}))) |-> (lane_busy == '0));
endmodule

// File: tb/sim_wf_issue_gate.sv
`timescale 1ns/1ps
module sim_wf_issue_gate;
  localparam int CW = 6, IP = 4, AB = 3, RB = 4, WB = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, buf_empty, opnd_ok, gfifo_room, lfifo_room, all_arrived, issue_en;
  logic [1:0] run_state, op_kind;
  logic [2:0] req_class;
  logic [3:0] op_cls, launch, retire;
  logic rdy, err, stalled, alu_busy;
  logic [CW-1:0] bar_rec;
  logic [4*CW-1:0] pipe_cnt, outs_cnt;

  wf_issue_gate u0 (
    .clk(clk), .rst(rst), .run_state(run_state), .buf_empty(buf_empty),
    .req_class(req_class), .op_cls(op_cls), .op_kind(op_kind), .opnd_ok(opnd_ok),
    .gfifo_room(gfifo_room), .lfifo_room(lfifo_room), .all_arrived(all_arrived),
    .issue_en(issue_en), .launch(launch), .retire(retire), .rdy(rdy), .err(err),
    .stalled(stalled), .alu_busy(alu_busy), .bar_rec(bar_rec),
    .pipe_cnt(pipe_cnt), .outs_cnt(outs_cnt)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int m_pipe[4], m_outs[4], m_tm[6];
  int m_bar, m_rec;
  bit m_stall;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_err();
    return (op_cls >= 8) || (op_cls >= 4 && op_kind == 2'd3);
  endfunction

  function automatic bit pend(int ln);
    return (m_pipe[ln] + m_outs[ln]) != 0;
  endfunction

  // expected readiness from R1..R6, R10, R11
  function automatic bit exp_rdy();
    bit rdl, wrl, go, lo, gp, lp;
    if (run_state != 2'd1 || buf_empty || (m_stall && !all_arrived) || exp_err()) return 0;
    rdl = (op_kind == 0) || (op_kind == 2);
    wrl = (op_kind == 1) || (op_kind == 2);
    go = !(rdl && pend(1)) && !(wrl && pend(0));
    lo = !(rdl && pend(3)) && !(wrl && pend(2));
    gp = (m_tm[1] == 0) && (m_tm[3] == 0) && gfifo_room;
    lp = (m_tm[2] == 0) && (m_tm[4] == 0) && lfifo_room;
    case (op_cls)
      0: return req_class == 0 && m_tm[0] == 0 && opnd_ok;
      1: return req_class == 0 && m_tm[0] == 0;
      2, 3: return req_class == 0 && m_tm[0] == 0 && !pend(0) && !pend(1) && !pend(2) && !pend(3);
      4: return req_class == 1 && go && gp && opnd_ok;
      6: return req_class == 3 && go && gp && opnd_ok;
      5: return req_class == 2 && lo && lp && opnd_ok;
      default: return req_class == 4 && gp && lp && opnd_ok;
    endcase
  endfunction

  function automatic string auto_tag();
    if (exp_err()) return "R11";
    if (run_state != 2'd1 || buf_empty) return "R1";
    if (m_stall) return "R10";
    case (op_cls)
      0, 1, 2, 3: return (req_class == 0) ? "R5" : "R2";
      4, 6: return (req_class == ((op_cls == 4) ? 1 : 3)) ? "R3" : "R2";
      5: return (req_class == 2) ? "R4" : "R2";
      default: return (req_class == 4) ? "R6" : "R2";
    endcase
  endfunction

  task automatic model_edge(bit er);
    bit iss, lg, gg;
    int bt;
    iss = issue_en && er;
    lg = (op_cls == 5);
    gg = (op_cls == 4 || op_cls == 6 || op_cls == 7);
    bt = (op_kind == 0) ? RB : WB;
    for (int i = 0; i < 4; i++) begin
      int inc;
      inc = 0;
      if (iss && (lg || gg)) begin
        if ((i == (lg ? 2 : 0)) && op_kind != 1) inc = 1;
        if ((i == (lg ? 3 : 1)) && op_kind != 0) inc = 1;
      end
      m_pipe[i] = m_pipe[i] + inc - int'(launch[i]);
      m_outs[i] = m_outs[i] + int'(launch[i]) - int'(retire[i]);
    end
    if (m_stall && all_arrived) begin m_stall = 0; m_rec = m_bar; end
    if (iss && op_cls == 2) begin m_stall = 1; m_bar = (m_bar + 1) % 64; end
    for (int k = 0; k < 6; k++) begin
      bit ld;
      int v;
      case (k)
        0: begin ld = iss && op_cls < 4; v = IP; end
        1: begin ld = iss && gg; v = IP; end
        2: begin ld = iss && lg; v = IP; end
        3: begin ld = iss && gg; v = bt; end
        4: begin ld = iss && lg; v = bt; end
        default: begin ld = iss && (op_cls == 0 || op_cls == 3); v = AB; end
      endcase
      if (ld) m_tm[k] = v;
      else if (m_tm[k] > 0) m_tm[k] = m_tm[k] - 1;
    end
  endtask

  // called just after a falling edge with inputs driven
  task automatic step(string tag);
    bit er;
    #1;
    er = exp_rdy();
    chk((tag == "") ? auto_tag() : tag, int'(rdy), int'(er));
    chk("R11", int'(err), int'(exp_err()));
    @(posedge clk);
    model_edge(er);
    #1;
    for (int i = 0; i < 4; i++) begin
      chk("R7", int'(pipe_cnt[i*CW +: CW]), m_pipe[i]);
      chk("R7", int'(outs_cnt[i*CW +: CW]), m_outs[i]);
    end
    chk("R10", int'(stalled), int'(m_stall));
    chk("R10", int'(bar_rec), m_rec);
    chk("R9", int'(alu_busy), int'(m_tm[5] != 0));
    @(negedge clk);
  endtask

  task automatic set_op(int rs, int rc, int oc, int ok, bit ie);
    run_state = 2'(rs); req_class = 3'(rc); op_cls = 4'(oc); op_kind = 2'(ok);
    issue_en = ie; buf_empty = 0; opnd_ok = 1; gfifo_room = 1; lfifo_room = 1;
    all_arrived = 0; launch = '0; retire = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (m_pipe[i]) begin m_pipe[i] = 0; m_outs[i] = 0; end
    foreach (m_tm[k]) m_tm[k] = 0;
    m_bar = 0; m_rec = 0; m_stall = 0;
    set_op(0, 0, 1, 0, 0);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: state right after reset
    #1;
    chk("R12", int'(pipe_cnt), 0);
    chk("R12", int'(outs_cnt), 0);
    chk("R12", int'(stalled), 0);
    chk("R12", int'(bar_rec), 0);
    chk("R12", int'(alu_busy), 0);
    @(negedge clk);

    // R8: global read, bus window of 4 then free on the next cycle
    set_op(1, 1, 4, 0, 1); step("R8");
    set_op(1, 1, 4, 0, 0);
    for (int c = 0; c < 5; c++) step("R8");
    // R3: global write blocked by the pending read
    set_op(1, 1, 4, 1, 0); step("R3");
    set_op(1, 1, 4, 1, 0); launch = 4'b0001; step("R7");
    set_op(1, 1, 4, 1, 0); retire = 4'b0001; step("R7");
    // write issues now; 8-cycle bus window
    set_op(1, 1, 4, 1, 1); step("R3");
    set_op(1, 1, 4, 1, 0);
    for (int c = 0; c < 4; c++) step("R8");
    set_op(1, 0, 1, 0, 0); step("R5");
    set_op(1, 1, 6, 2, 0); step("R3");
    set_op(1, 0, 2, 0, 0); step("R5");
    set_op(1, 0, 0, 0, 0); launch = 4'b0010; step("R7");
    set_op(1, 0, 0, 0, 0); retire = 4'b0010; step("R7");
    // R10: barrier issue, hold, release
    set_op(1, 0, 2, 0, 1); step("R5");
    set_op(1, 0, 1, 0, 1);
    for (int c = 0; c < 6; c++) step("R10");
    all_arrived = 1; step("R10");
    set_op(1, 0, 1, 0, 0); step("R10");
    // R11: unknown codes
    set_op(1, 0, 9, 0, 1); step("R11");
    set_op(1, 2, 5, 3, 1); step("R11");
    // R6: flat needs both paths
    set_op(1, 4, 7, 0, 0); lfifo_room = 0; step("R6");
    set_op(1, 4, 7, 0, 1); step("R6");

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      run_state = (r < 88) ? 2'd1 : 2'($urandom_range(0, 3));
      buf_empty = ($urandom_range(0, 9) == 0);
      op_cls = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(8, 15)) : 4'($urandom_range(0, 7));
      op_kind = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      if ($urandom_range(0, 3) != 0) begin
        case (op_cls)
          0, 1, 2, 3: req_class = 0;
          4: req_class = 1;
          5: req_class = 2;
          6: req_class = 3;
          default: req_class = 4;
        endcase
      end else req_class = 3'($urandom_range(0, 7));
      opnd_ok = ($urandom_range(0, 4) != 0);
      gfifo_room = ($urandom_range(0, 6) != 0);
      lfifo_room = ($urandom_range(0, 6) != 0);
      all_arrived = ($urandom_range(0, 3) == 0);
      issue_en = ($urandom_range(0, 1) == 1);
      for (int i = 0; i < 4; i++) begin
        launch[i] = (m_pipe[i] > 0) && ($urandom_range(0, 2) == 0);
        retire[i] = (m_outs[i] > 0) && ($urandom_range(0, 2) == 0);
      end
      step("");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule